// File: doc/BRIEF.md
# Quadrature phase clock generator

This block watches a slow input clock through a fast sampling clock and rebuilds four copies of it at the same frequency, offset by a quarter, a half and three quarters of the input period. The input period is measured as a whole number of sampling cycles between consecutive rising edges. The high time is measured in the same way. Each output is then drawn from a position counter that restarts on every input rising edge.

Two static controls shape the outputs. With duty-cycle correction on, every output is high for half the measured period, rounded down, whatever the input's own high time. With correction off, every output copies the input's measured high time. In high-frequency mode only the zero and half-period outputs run, and the quarter and three-quarter outputs are held low.

The outputs stay low until the input has shown two consecutive periods of equal length, at least four samples each. They fall back to low as soon as an expected input edge fails to arrive on time.

Top module: `quad_phase_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all four outputs are low.
- R2: Once running with input period P samples, all four outputs repeat every P samples. The rising edges of the 90, 180 and 270 outputs follow the 0 output's rising edge by floor(P/4), floor(P/2) and floor(3P/4) samples.
- R3: With `dcc_en` high, every running output is high for floor(P/2) samples of each period. As a result, the 0 and 180 outputs are never high together.
- R4: With `dcc_en` low, every running output is high for as many samples as the input was high during the previous measured period.
- R5: With `hf_mode` high, `ph90` and `ph270` are held low, while `ph0` and `ph180` keep running.
- R6: No output goes high until the third input rising edge after reset, which closes two equal periods. Successive periods of differing length keep all outputs low.
- R7: A measured period shorter than 4 samples keeps all outputs low.
- R8: If the input rising edge does not arrive within the locked period, all outputs go low and stay low until lock is regained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 1 | Input clock as sampled on `clk` |
| dcc_en | input | 1 | 1 = force 50% duty on outputs |
| hf_mode | input | 1 | 1 = only 0 and 180 outputs run |
| ph0 | output | 1 | Copy at 0 degrees |
| ph90 | output | 1 | Copy at a quarter period |
| ph180 | output | 1 | Copy at half period |
| ph270 | output | 1 | Copy at three quarters of a period |

## Verification
The assertions take `smp_in` to be already synchronous to `clk`. They count its rising edges from reset exactly as the block does, and they take `dcc_en` and `hf_mode` to be settled one cycle before the output they judge. The stimulus drives every input on the falling edge of `clk`. It keeps each mode fixed for a whole scenario and resets between scenarios, so the rising-edge count the checker keeps always matches the block's own.

// File: rtl/qpg_pkg.sv
package qpg_pkg;
  localparam int NUM_PHASES = 4;
  localparam int MIN_PERIOD = 4;
  typedef enum logic [1:0] {
    PH_0   = 2'd0,
    PH_90  = 2'd1,
    PH_180 = 2'd2,
    PH_270 = 2'd3
  } phase_e;
endpackage

// File: rtl/qpg_edge_meter.sv
module qpg_edge_meter #(
  parameter int CNT_W   = 8,
  parameter int MIN_PER = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_in,
  output logic             locked,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] lk_per,
  output logic [CNT_W-1:0] lk_high
);
  localparam logic [CNT_W-1:0] POS_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_PER);

  logic             in_d, seen, have_prev;
  logic [CNT_W-1:0] hcnt, prev_per, meas;
  logic             rise, sat, match;

  assign rise  = smp_in & ~in_d;
  assign sat   = (pos == POS_MAX);
  assign meas  = pos + 1'b1;
  assign match = seen && have_prev && !sat && (meas == prev_per) && (meas >= MIN_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_d      <= 1'b0;
      seen      <= 1'b0;
      have_prev <= 1'b0;
      pos       <= '0;
      hcnt      <= '0;
      prev_per  <= '0;
      locked    <= 1'b0;
      lk_per    <= '0;
      lk_high   <= '0;
    end else begin
      in_d <= smp_in;
      if (rise) begin
        pos  <= '0;
        hcnt <= CNT_W'(1);
        seen <= 1'b1;
        if (seen) begin
          prev_per  <= sat ? '0 : meas;
          have_prev <= !sat;
          locked    <= match;
          if (match) begin
            lk_per  <= meas;
            lk_high <= hcnt;
          end
        end
      end else begin
        if (!sat) pos <= meas;
        if (smp_in && hcnt != POS_MAX) hcnt <= hcnt + 1'b1;
        if (locked && pos == lk_per - 1'b1) locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qpg_phase_slot.sv
module qpg_phase_slot #(
  parameter int CNT_W   = 8,
  parameter int QUARTER = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             dcc_en,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] high,
  output logic             ph_out
);
  localparam logic [CNT_W+1:0] QMUL = (CNT_W+2)'(QUARTER);

  logic [CNT_W+1:0] prod;
  logic [CNT_W-1:0] offset, rel, hi_len;

  assign prod   = {2'b00, per} * QMUL;
  assign offset = prod[CNT_W+1:2];
  assign rel    = (pos >= offset) ? (pos - offset) : (pos + (per - offset));
  assign hi_len = dcc_en ? (per >> 1) : high;

  always_ff @(posedge clk) begin
    if (rst) ph_out <= 1'b0;
    else     ph_out <= run && (rel < hi_len);
  end
endmodule

// File: rtl/quad_phase_gen.sv
module quad_phase_gen #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_in,
  input  logic dcc_en,
  input  logic hf_mode,
  output logic ph0,
  output logic ph90,
  output logic ph180,
  output logic ph270
);
  import qpg_pkg::*;

  logic             locked;
  logic [CNT_W-1:0] pos, lk_per, lk_high;
  logic [NUM_PHASES-1:0] ph_vec;

  qpg_edge_meter #(.CNT_W(CNT_W), .MIN_PER(MIN_PERIOD)) u_meter (
    .clk     (clk),
    .rst     (rst),
    .smp_in  (smp_in),
    .locked  (locked),
    .pos     (pos),
    .lk_per  (lk_per),
    .lk_high (lk_high)
  );

  for (genvar k = 0; k < NUM_PHASES; k++) begin : g_slot
    logic allowed;
    if (k % 2 == 0) begin : g_even
      assign allowed = 1'b1;
    end else begin : g_odd
      assign allowed = !hf_mode;
    end
    qpg_phase_slot #(.CNT_W(CNT_W), .QUARTER(k)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .run    (locked && allowed),
      .dcc_en (dcc_en),
      .pos    (pos),
      .per    (lk_per),
      .high   (lk_high),
      .ph_out (ph_vec[k])
    );
  end

  assign ph0   = ph_vec[PH_0];
  assign ph90  = ph_vec[PH_90];
  assign ph180 = ph_vec[PH_180];
  assign ph270 = ph_vec[PH_270];
endmodule

// File: rtl/qpg_checker.sv
module qpg_checker (
  input logic clk,
  input logic rst,
  input logic smp_in,
  input logic dcc_en,
  input logic hf_mode,
  input logic ph0,
  input logic ph90,
  input logic ph180,
  input logic ph270
);
  logic       prev_in;
  logic [1:0] rise_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_in   <= 1'b0;
      rise_seen <= 2'd0;
    end else begin
      prev_in <= smp_in;
      if (smp_in && !prev_in && rise_seen != 2'd3) rise_seen <= rise_seen + 2'd1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(ph0 || ph90 || ph180 || ph270));

  // R5
  hf_quarter_off_chk: assert property (@(posedge clk) disable iff (rst)
    hf_mode |=> (!ph90 && !ph270));

  // R6
  no_early_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_seen != 2'd3) |-> !(ph0 || ph90 || ph180 || ph270));

  // R3
  dcc_half_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    dcc_en |=> !(ph0 && ph180));
endmodule

bind quad_phase_gen qpg_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .smp_in  (smp_in),
  .dcc_en  (dcc_en),
  .hf_mode (hf_mode),
  .ph0     (ph0),
  .ph90    (ph90),
  .ph180   (ph180),
  .ph270   (ph270)
);

// File: tb/quad_phase_gen_bench.sv
module quad_phase_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_in = 1'b0;
  logic dcc_en = 1'b0;
  logic hf_mode = 1'b0;
  logic ph0, ph90, ph180, ph270;

  int checks = 0;
  int failures = 0;
  logic [3:0] rec [0:511];

  always #5 clk = ~clk;

  quad_phase_gen u_quad_phase_gen (
    .clk(clk), .rst(rst), .smp_in(smp_in), .dcc_en(dcc_en), .hf_mode(hf_mode),
    .ph0(ph0), .ph90(ph90), .ph180(ph180), .ph270(ph270)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit dcc, input bit hf);
    @(negedge clk);
    rst = 1'b1; smp_in = 1'b0; dcc_en = dcc; hf_mode = hf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic record_wave(input int per, input int hi, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rec[i] = {ph270, ph180, ph90, ph0};
      smp_in = ((i % per) < hi);
    end
  endtask

  function automatic int count_high(input int from, input int to);
    int c = 0;
    for (int i = from; i < to; i++) c += (rec[i] != 4'd0) ? 1 : 0;
    return c;
  endfunction

  // R2 offsets/period, R3/R4 high time, R5 quarter outputs in hf mode
  task automatic check_pattern(input int per, input int hexp, input bit hf, input string req);
    int t0 = -1;
    for (int i = 6 * per; i < 8 * per; i++)
      if (t0 < 0 && rec[i][0] && !rec[i-1][0]) t0 = i;
    check(t0 >= 0, {req, " R2 ph0 rising edge found"}, t0, 1);
    if (t0 >= 0) begin
      for (int k = 0; k < 4; k++) begin
        int bad = 0;
        int d = (k * per) / 4;
        for (int j = 0; j < 2 * per; j++) begin
          int rel = (j - d + 2 * per) % per;
          bit exp = ((k % 2 == 1) && hf) ? 1'b0 : (rel < hexp);
          if (rec[t0 + j][k] != exp) bad++;
        end
        check(bad == 0, $sformatf("%s phase%0d", req, k * 90), bad, 0);
      end
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    check({ph270, ph180, ph90, ph0} == 4'd0, "R1 outputs low after reset",
          int'({ph270, ph180, ph90, ph0}), 0);
  endtask

  task automatic t_copy_duty;
    do_reset(1'b0, 1'b0);
    record_wave(12, 4, 144);
    check_pattern(12, 4, 1'b0, "R2 R4 P12 H4 copy");
    do_reset(1'b0, 1'b0);
    record_wave(11, 3, 132);
    check_pattern(11, 3, 1'b0, "R2 R4 P11 H3 copy");
  endtask

  task automatic t_corrected;
    do_reset(1'b1, 1'b0);
    record_wave(12, 4, 144);
    check_pattern(12, 6, 1'b0, "R3 P12 corrected");
    do_reset(1'b1, 1'b0);
    record_wave(10, 7, 120);
    check_pattern(10, 5, 1'b0, "R3 P10 corrected");
  endtask

  task automatic t_hf;
    do_reset(1'b1, 1'b1);
    record_wave(16, 3, 192);
    check_pattern(16, 8, 1'b1, "R5 hf P16");
  endtask

  task automatic t_lock_wait;
    // R6: third rise is input sample 2P; nothing may be high by then
    do_reset(1'b0, 1'b0);
    record_wave(12, 6, 60);
    check(count_high(0, 25) == 0, "R6 low before two equal periods", count_high(0, 25), 0);
  endtask

  task automatic t_unequal;
    int idx = 0;
    do_reset(1'b1, 1'b0);
    for (int p = 0; p < 16; p++) begin
      int per = (p % 2 == 0) ? 8 : 12;
      for (int j = 0; j < per; j++) begin
        @(negedge clk);
        rec[idx] = {ph270, ph180, ph90, ph0};
        smp_in = (j < per / 2);
        idx++;
      end
    end
    check(count_high(0, idx) == 0, "R6 unequal periods stay low", count_high(0, idx), 0);
  endtask

  task automatic t_short;
    do_reset(1'b1, 1'b0);
    record_wave(3, 1, 120);
    check(count_high(0, 120) == 0, "R7 period 3 stays low", count_high(0, 120), 0);
  endtask

  task automatic t_stop;
    do_reset(1'b1, 1'b0);
    record_wave(12, 6, 120);
    check(count_high(100, 120) > 0, "R8 running before stop", count_high(100, 120), 1);
    for (int i = 120; i < 180; i++) begin
      @(negedge clk);
      rec[i] = {ph270, ph180, ph90, ph0};
      smp_in = 1'b0;
    end
    check(count_high(135, 180) == 0, "R8 outputs low after missing edge", count_high(135, 180), 0);
  endtask

  initial begin
    t_reset();
    t_copy_duty();
    t_corrected();
    t_hf();
    t_lock_wait();
    t_unequal();
    t_short();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule